// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the memory bus and an instruction decoder. It fetches code bytes one at a time from the physical address formed by a 16-bit code segment and a 16-bit fetch offset. It keeps up to six of them in arrival order and hands them to the decoder over a valid/ready stream. Fetching runs ahead whenever the bus is idle and the queue has room. An execution-side data access always wins an idle bus over a prefetch, so the queue only fills in bus cycles that execution does not use.

A redirect pulse (jump or call) loads a new segment and offset and empties the queue. If a prefetch is still outstanding on the bus at that moment, it is marked stale, and its returning byte is thrown away. Fetching then restarts at the new address.

Decoder stream rules: `dec_byte` is the oldest queued byte whenever `dec_valid` is high. A byte is consumed on a rising edge where `dec_valid` and `dec_ready` are both high and `redir_valid` is low. While `dec_ready` is low, the offered byte stays unchanged. Memory bus rules: one transaction at a time. A request is taken on the edge where `mem_req` and `mem_gnt` are both high. Exactly one `mem_rvalid` pulse must follow, no earlier than the next cycle, and the next request appears only after that pulse. Before it is granted, a request may change or be withdrawn.

Top module: `ifetch_prefetch_queue`

## Requirements
- R1: The queue never holds more than six bytes, and `dec_valid` is high exactly when at least one byte is held.
- R2: Bytes reach `dec_byte` in the order their fetches were granted. While `dec_valid` is high and `dec_ready` is low, `dec_valid` stays high and `dec_byte` stays stable into the next cycle, unless a redirect occurs.
- R3: Every prefetch request is a read (`mem_we` = 0) at address segment × 16 + offset, taken modulo 2^20.
- R4: The fetch offset advances by one per granted prefetch and wraps from 16'hFFFF to 16'h0000 without carrying into the segment.
- R5: No prefetch request is made while the held bytes plus any live prefetch in flight total six.
- R6: When the bus is idle and `ex_req` is high, the bus carries the execution access: its address, its write flag and its write data. In that case `ex_gnt` equals `mem_gnt`. The read data comes back on `ex_rdata` with `ex_rvalid` and never enters the queue.
- R7: A redirect discards every held byte. `dec_valid` is low in the cycle after the redirect, and the first byte delivered afterwards comes from the new segment:offset.
- R8: When a decoder handshake and a redirect happen in the same cycle, the redirect wins. The handshake does not count as a consumed byte, and `dec_valid` is low the next cycle.
- R9: The response to a prefetch that was outstanding when a redirect arrived is dropped and not enqueued.
- R10: While a transaction is outstanding, `mem_req` and `ex_gnt` stay low.
- R11: After reset, `dec_valid` is low and the first prefetch uses the reset segment:offset (default F000:FFF0, physical FFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redir_valid | input | 1 | Redirect pulse: flush the queue and load a new fetch pointer |
| redir_seg | input | 16 | New code segment |
| redir_off | input | 16 | New fetch offset |
| dec_valid | output | 1 | A byte is offered to the decoder |
| dec_ready | input | 1 | Decoder accepts the offered byte |
| dec_byte | output | 8 | Oldest queued instruction byte |
| ex_req | input | 1 | Execution-side data access request |
| ex_we | input | 1 | Execution access is a write |
| ex_addr | input | 20 | Execution access physical address |
| ex_wdata | input | 8 | Execution write data |
| ex_gnt | output | 1 | Execution access taken by the bus this cycle |
| ex_rvalid | output | 1 | Execution access response |
| ex_rdata | output | 8 | Execution read data |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write flag |
| mem_addr | output | 20 | Bus physical address |
| mem_wdata | output | 8 | Bus write data |
| mem_gnt | input | 1 | Bus accepts the request this cycle |
| mem_rvalid | input | 1 | Bus response for the outstanding transaction |
| mem_rdata | input | 8 | Bus response data |

## Verification
A wrong fetch pointer shows on `mem_addr` at the very next prefetch grant. A wrong queue pointer or count shows as a misordered, duplicated or missing byte on `dec_byte` at the next handshake, or as a seventh prefetch request during a long decoder stall. A lost stale flag shows within one bus latency after a redirect: an old byte appears first in the new stream. A wrong bus-ownership record shows as an execution read byte turning up in the instruction stream, or as a request raised while a response is still pending.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  // who currently owns the single outstanding bus transaction
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_EXEC  = 2'd2
  } bus_owner_e;
endpackage

// File: rtl/ipq_byte_fifo.sv
module ipq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int W     = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [W-1:0]     slots [DEPTH];
  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic             do_wr, do_rd;

  assign do_wr = wr_en && !flush && (count < CNT_W'(DEPTH));
  assign do_rd = rd_en && !flush && (count != '0);

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // one write-enabled register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wr_ptr == IDX_W'(i))) slots[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end

  assign rd_data = slots[rd_ptr];
  assign empty   = (count == '0);
endmodule

// File: rtl/ipq_fetch_ptr.sv
module ipq_fetch_ptr #(
  parameter int               SEG_W   = 16,
  parameter int               OFF_W   = 16,
  parameter int               PA_W    = 20,
  parameter int               SHIFT   = 4,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hF000,
  parameter logic [OFF_W-1:0] RST_OFF = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_seg,
  input  logic [OFF_W-1:0] load_off,
  input  logic             advance,
  output logic [PA_W-1:0]  phys_addr
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  seg_sh, off_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (load) begin
      seg_q <= load_seg;
      off_q <= load_off;
    end else if (advance) begin
      off_q <= off_q + 1'b1;   // wraps inside the offset width
    end
  end

  assign seg_sh    = PA_W'(seg_q) << SHIFT;
  assign off_ext   = PA_W'(off_q);
  assign phys_addr = seg_sh + off_ext;
endmodule

// File: rtl/ipq_bus_arb.sv
module ipq_bus_arb
  import ipq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ex_req,
  input  logic fetch_want,
  input  logic flush,
  input  logic mem_gnt,
  input  logic mem_rvalid,
  output logic sel_exec,
  output logic sel_fetch,
  output logic busy,
  output logic fetch_live,
  output logic fetch_fill,
  output logic exec_rsp
);
  logic       busy_q;
  bus_owner_e owner_q;
  logic       stale_q;
  logic       idle;

  assign idle      = !busy_q;
  assign sel_exec  = idle && ex_req;
  assign sel_fetch = idle && !ex_req && fetch_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= OWN_NONE;
      stale_q <= 1'b0;
    end else if ((sel_exec || sel_fetch) && mem_gnt) begin
      busy_q  <= 1'b1;
      owner_q <= sel_exec ? OWN_EXEC : OWN_FETCH;
      stale_q <= sel_fetch && flush;
    end else if (busy_q && mem_rvalid) begin
      busy_q  <= 1'b0;
      owner_q <= OWN_NONE;
      stale_q <= 1'b0;
    end else if (flush && busy_q && owner_q == OWN_FETCH) begin
      stale_q <= 1'b1;
    end
  end

  assign busy       = busy_q;
  assign fetch_live = busy_q && owner_q == OWN_FETCH && !stale_q;
  assign fetch_fill = fetch_live && mem_rvalid && !flush;
  assign exec_rsp   = busy_q && owner_q == OWN_EXEC && mem_rvalid;
endmodule

// File: rtl/ifetch_prefetch_queue.sv
module ifetch_prefetch_queue #(
  parameter int               DEPTH   = 6,
  parameter int               BYTE_W  = 8,
  parameter int               SEG_W   = 16,
  parameter int               OFF_W   = 16,
  parameter int               PA_W    = 20,
  parameter int               SHIFT   = 4,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hF000,
  parameter logic [OFF_W-1:0] RST_OFF = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [SEG_W-1:0]  redir_seg,
  input  logic [OFF_W-1:0]  redir_off,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [BYTE_W-1:0] dec_byte,
  input  logic              ex_req,
  input  logic              ex_we,
  input  logic [PA_W-1:0]   ex_addr,
  input  logic [BYTE_W-1:0] ex_wdata,
  output logic              ex_gnt,
  output logic              ex_rvalid,
  output logic [BYTE_W-1:0] ex_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] fill_level;
  logic [CNT_W:0]   committed;
  logic             q_empty, room, fetch_want;
  logic             sel_exec, sel_fetch, bus_busy, fetch_live, fetch_fill, exec_rsp;
  logic [PA_W-1:0]  fetch_addr;

  // bytes held plus a live fetch on the bus must stay below the depth
  assign committed  = {1'b0, fill_level} + {{CNT_W{1'b0}}, fetch_live};
  assign room       = committed < (CNT_W + 1)'(DEPTH);
  assign fetch_want = room && !redir_valid;

  ipq_bus_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_req     (ex_req),
    .fetch_want (fetch_want),
    .flush      (redir_valid),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .sel_exec   (sel_exec),
    .sel_fetch  (sel_fetch),
    .busy       (bus_busy),
    .fetch_live (fetch_live),
    .fetch_fill (fetch_fill),
    .exec_rsp   (exec_rsp)
  );

  ipq_fetch_ptr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(SHIFT),
    .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (redir_valid),
    .load_seg  (redir_seg),
    .load_off  (redir_off),
    .advance   (sel_fetch && mem_gnt),
    .phys_addr (fetch_addr)
  );

  ipq_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (redir_valid),
    .wr_en   (fetch_fill),
    .wr_data (mem_rdata),
    .rd_en   (dec_valid && dec_ready),
    .rd_data (dec_byte),
    .count   (fill_level),
    .empty   (q_empty)
  );

  assign dec_valid = !q_empty;

  assign mem_req   = sel_exec || sel_fetch;
  assign mem_we    = sel_exec && ex_we;
  assign mem_addr  = sel_exec ? ex_addr : fetch_addr;
  assign mem_wdata = ex_wdata;
  assign ex_gnt    = sel_exec && mem_gnt;
  assign ex_rvalid = exec_rsp;
  assign ex_rdata  = mem_rdata;
endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int PA_W   = 20,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic [BYTE_W-1:0] dec_byte,
  input logic              ex_req,
  input logic [PA_W-1:0]   ex_addr,
  input logic              ex_gnt,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [PA_W-1:0]   mem_addr,
  input logic              mem_rvalid,
  input logic [CNT_W-1:0]  fill_level,
  input logic              bus_busy
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH)); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready && !redir_valid |=> dec_valid && $stable(dec_byte)); // R2

  AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CNT_W'(DEPTH)) && !ex_req |-> !mem_req); // R5

  AST_EXEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ex_req && !bus_busy |-> mem_req && (mem_addr == ex_addr) && (ex_gnt == mem_gnt)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !dec_valid); // R7

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !mem_req && !ex_gnt); // R10

  AST_RSP_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> bus_busy); // R10
endmodule

bind ifetch_prefetch_queue ipq_checker #(
  .DEPTH(DEPTH), .BYTE_W(BYTE_W), .PA_W(PA_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .redir_valid (redir_valid),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_byte    (dec_byte),
  .ex_req      (ex_req),
  .ex_addr     (ex_addr),
  .ex_gnt      (ex_gnt),
  .mem_req     (mem_req),
  .mem_gnt     (mem_gnt),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .fill_level  (fill_level),
  .bus_busy    (bus_busy)
);

// File: tb/tb_ifetch_prefetch_queue.sv
`timescale 1ns/100ps
module tb_ifetch_prefetch_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_seg = '0, redir_off = '0;
  logic        dec_valid, dec_ready = 1'b0;
  logic [7:0]  dec_byte;
  logic        ex_req = 1'b0, ex_we = 1'b0;
  logic [19:0] ex_addr = '0;
  logic [7:0]  ex_wdata = '0;
  logic        ex_gnt, ex_rvalid;
  logic [7:0]  ex_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;

  always #2.5 clk = ~clk;

  ifetch_prefetch_queue dut (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_byte(dec_byte),
    .ex_req(ex_req), .ex_we(ex_we), .ex_addr(ex_addr), .ex_wdata(ex_wdata),
    .ex_gnt(ex_gnt), .ex_rvalid(ex_rvalid), .ex_rdata(ex_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] fmem(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h3C;
  endfunction

  // ---------------- memory model ----------------
  logic        gnt_en = 1'b1;
  int          lat_cfg = 0;
  logic        pend = 1'b0, pend_we = 1'b0;
  logic [19:0] pend_addr = '0;
  int          lat_cnt = 0;
  logic [19:0] wr_seen_addr = '0;
  logic [7:0]  wr_seen_data = '0;

  assign mem_gnt = mem_req && gnt_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= pend_we ? 8'h00 : fmem(pend_addr);
          pend <= 1'b0;
        end else lat_cnt <= lat_cnt - 1;
      end else if (mem_req && mem_gnt) begin
        pend <= 1'b1; pend_addr <= mem_addr; pend_we <= mem_we; lat_cnt <= lat_cfg;
        if (mem_we) begin wr_seen_addr <= mem_addr; wr_seen_data <= mem_wdata; end
      end
    end
  end

  // ---------------- scoreboard and monitor ----------------
  logic [7:0]  exp_q [$];
  logic [15:0] exp_seg = 16'hF000, exp_off = 16'hFFF0;
  int          fetch_cnt = 0;

  task automatic push_stream(input logic [15:0] s, input logic [15:0] o);
    exp_q.delete();
    for (int i = 0; i < 64; i++) exp_q.push_back(fmem(phys(s, o + 16'(i))));
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dec_valid && dec_ready && !redir_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 byte with empty scoreboard", {24'h0, dec_byte}, 32'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(dec_byte == e, "R2 order", {24'h0, dec_byte}, {24'h0, e});
        end
      end
      if (mem_req && mem_gnt && !ex_req) begin
        chk(mem_addr == phys(exp_seg, exp_off) && !mem_we, "R3 fetch address",
            {12'h0, mem_addr}, {12'h0, phys(exp_seg, exp_off)});
        exp_off++;
        fetch_cnt++;
      end
      if (ex_req && mem_req && mem_gnt)
        chk(mem_addr == ex_addr, "R6 exec owns bus", {12'h0, mem_addr}, {12'h0, ex_addr});
      if (redir_valid) begin exp_seg = redir_seg; exp_off = redir_off; fetch_cnt = 0; end
    end
  end

  task automatic redirect(input logic [15:0] s, input logic [15:0] o);
    @(posedge clk); #1;
    redir_valid = 1'b1; redir_seg = s; redir_off = o;
    push_stream(s, o);
    @(posedge clk); #1;
    redir_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    push_stream(16'hF000, 16'hFFF0);
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0, "R11 reset dec_valid", {31'h0, dec_valid}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R11: first prefetch at the reset vector
    @(negedge clk);
    while (!(mem_req && mem_gnt)) @(negedge clk);
    chk(mem_addr == 20'hFFFF0, "R11 first fetch", {12'h0, mem_addr}, 32'hFFFF0);

    // R5 / R1: decoder stalled, queue fills to six and fetching stops
    repeat (40) @(negedge clk);
    chk(fetch_cnt == 6, "R5 fetch count at full", fetch_cnt, 6);
    chk(mem_req == 1'b0, "R5 no request when full", {31'h0, mem_req}, 32'h0);
    chk(dec_valid == 1'b1, "R1 valid when holding", {31'h0, dec_valid}, 32'h1);

    // R2 / R4: drain across the offset wrap FFFF -> 0000
    @(posedge clk); #1; dec_ready = 1'b1;
    repeat (30) @(posedge clk);
    #1; dec_ready = 1'b0;

    // R4: explicit wrap inside a new segment
    redirect(16'h1234, 16'hFFFE);
    repeat (20) @(negedge clk);
    chk(dec_byte == fmem(20'h2233E), "R4 head before wrap", {24'h0, dec_byte}, {24'h0, fmem(20'h2233E)});
    @(posedge clk); #1; dec_ready = 1'b1; @(posedge clk); #1; dec_ready = 1'b0;
    @(negedge clk);
    chk(dec_byte == fmem(20'h2233F), "R4 last before wrap", {24'h0, dec_byte}, {24'h0, fmem(20'h2233F)});
    @(posedge clk); #1; dec_ready = 1'b1; @(posedge clk); #1; dec_ready = 1'b0;
    @(negedge clk);
    chk(dec_byte == fmem(20'h12340), "R4 wrapped offset", {24'h0, dec_byte}, {24'h0, fmem(20'h12340)});

    // R2: irregular back-pressure and grant gaps with latency
    lat_cfg = 2;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      dec_ready = (i % 3) != 0;
      gnt_en    = (i % 5) != 2;
    end
    gnt_en = 1'b1;

    // R6: exec read then write while prefetching
    lat_cfg = 1;
    @(posedge clk); #1; ex_req = 1'b1; ex_we = 1'b0; ex_addr = 20'h34567;
    @(negedge clk); while (!ex_gnt) @(negedge clk);
    chk(!mem_we, "R6 exec read flag", {31'h0, mem_we}, 32'h0);
    @(posedge clk); #1; ex_req = 1'b0;
    @(negedge clk); while (!ex_rvalid) @(negedge clk);
    chk(ex_rdata == fmem(20'h34567), "R6 exec read data", {24'h0, ex_rdata}, {24'h0, fmem(20'h34567)});
    @(posedge clk); #1; ex_req = 1'b1; ex_we = 1'b1; ex_addr = 20'h0ABCD; ex_wdata = 8'hA5;
    @(negedge clk); while (!ex_gnt) @(negedge clk);
    @(posedge clk); #1; ex_req = 1'b0; ex_we = 1'b0;
    @(negedge clk);
    chk(wr_seen_addr == 20'h0ABCD && wr_seen_data == 8'hA5, "R6 exec write",
        {4'h0, wr_seen_addr, wr_seen_data}, {4'h0, 20'h0ABCD, 8'hA5});
    repeat (20) @(posedge clk);

    // R7 / R8: redirect while a byte is being consumed
    lat_cfg = 0;
    @(negedge clk); while (!dec_valid) @(negedge clk);
    redirect(16'h4000, 16'h0100);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R8 flush beats read", {31'h0, dec_valid}, 32'h0);
    while (!dec_valid) @(negedge clk);
    chk(dec_byte == fmem(20'h40100), "R7 first byte of new stream", {24'h0, dec_byte}, {24'h0, fmem(20'h40100)});
    repeat (15) @(posedge clk);

    // R9 / R10: redirect while a slow prefetch is outstanding
    lat_cfg = 8;
    repeat (12) @(posedge clk);
    @(negedge clk); while (!(mem_req && mem_gnt && !ex_req)) @(negedge clk);
    @(negedge clk);
    chk(mem_req == 1'b0, "R10 no request while outstanding", {31'h0, mem_req}, 32'h0);
    redirect(16'h5000, 16'h0200);
    lat_cfg = 0;
    @(negedge clk); while (!dec_valid) @(negedge clk);
    chk(dec_byte == fmem(20'h50200), "R9 stale byte dropped", {24'h0, dec_byte}, {24'h0, fmem(20'h50200)});
    repeat (40) @(posedge clk);
    #1; dec_ready = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule